// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives a user clock for an output pin from the system clock. An 8-bit control word selects the divide factor, the duty-cycle shape and the output polarity, and carries a one-shot clear command. A separate enable from the port logic starts and stops the clock. The clock stops only at the end of a whole period, so no short pulse appears on the pin.

A new divide factor or duty shape written while the divider runs is held until the output period in progress ends. The hardware then applies it, so software needs no handshake. Writing the clear command abandons the period at once and forces the generated clock low. The same write may carry a new factor, and counting restarts with it on the next cycle. Reading the clear bit position returns an idle flag. Software can poll this flag to learn that the clock has really stopped after it drops the enable. The polarity inverter is the last stage of the path, so a stopped clock rests at the inverted level.

Top module: `clkout_divider`

## Requirements
- R1: After reset the read-back word is 8'h80 (idle flag set, all control fields 0) and `clk_out` is 0.
- R2: With control bit 5 (duty select) at 1 and divide field bits 4:0 holding N in 1..31, the output period is 2N system cycles: N cycles high followed by N cycles low.
- R3: With bit 5 at 0 and N in 1..31, each period of 2N cycles has exactly one high cycle followed by 2N-1 low cycles.
- R4: With divide field 0 and the enable high, `clk_out` follows the system clock (high in its high phase, low in its low phase), and the idle flag reads 1.
- R5: A write of a new divide field or duty select without the clear bit, while the divider runs, leaves the period in progress unchanged. The next period uses the new setting.
- R6: Writing bit 7 (clear) as 1 drives the generated clock to 0 and the divider to idle in the cycle after the write edge. If the enable is high, the divider restarts one cycle later with the divide field written in the same word.
- R7: Read bit 7 is 1 when no divide-by-2N count is running and 0 while one is running.
- R8: When the enable falls during a period, that period completes with its full length. The divider then goes idle and the output stays at its rest level.
- R9: Control bit 6 inverts the final output. A stopped clock rests at the value of bit 6, and a change of bit 6 reaches `clk_out` in the cycle right after the write edge, even while the clock runs.
- R10: The clear bit is never stored. Read bits 6:0 return the last written invert, duty and divide values, and read bit 7 always shows the live idle status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word: [7] clear, [6] invert, [5] duty select, [4:0] divide field |
| rd_data | output | 8 | Read-back: [7] idle flag, [6:0] stored control fields |
| port_clk_en | input | 1 | Clock enable from the port logic |
| clk_out | output | 1 | Generated user clock |

## Verification
A wrong count or a wrong latched factor inside the divider shows at the pin as a wrong high or low run length, and it shows within one output period (at most 62 cycles). The bench therefore measures run lengths directly. A switch applied too early or too late changes the length of the period in which the write lands. Stale gating or a stale idle state shows as a wrong rest level, or as an idle flag that disagrees with the pin, in the cycle after the clear or in the cycle after the final period ends.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DIV_W = 5;
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic             inv;
        logic             sym;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_DIV  = 2'd1,
        MODE_PASS = 2'd2
    } mode_e;

    // last count of a 2N-cycle period
    function automatic logic [CNT_W-1:0] period_last(input logic [DIV_W-1:0] n);
        return {n, 1'b0} - CNT_W'(1);
    endfunction

    // output level of the divided clock at a given count
    function automatic logic phase_high(input logic [CNT_W-1:0] cnt,
                                        input logic [DIV_W-1:0] n,
                                        input logic             sym);
        if (sym)
            return cnt < {1'b0, n};
        else
            return cnt == '0;
    endfunction

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       busy,
    output ctrl_t      ctrl,
    output logic       clr_pulse,
    output logic [7:0] rd_data
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data[6:0];
    end

    // clear is a strobe only; nothing of it is kept
    assign clr_pulse = wr_en & wr_data[7];
    assign ctrl      = ctrl_q;
    assign rd_data   = {~busy, ctrl_q};

    // after a clear the status must read idle (R6, R10)
    assert_clear_reads_idle_R10: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> rd_data[7]);

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             sym,
    output logic             pulse,
    output logic             pass_req,
    output logic             busy
);

    mode_e            mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] cur_n_q;
    logic             cur_sym_q;
    logic             out_q;

    logic [CNT_W-1:0] last;
    logic             at_end;
    logic [CNT_W-1:0] cnt_inc;

    assign last    = period_last(cur_n_q);
    assign at_end  = (cnt_q == last);
    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_IDLE;
            cnt_q     <= '0;
            cur_n_q   <= '0;
            cur_sym_q <= 1'b0;
            out_q     <= 1'b0;
        end else if (clr) begin
            mode_q <= MODE_IDLE;
            cnt_q  <= '0;
            out_q  <= 1'b0;
        end else begin
            case (mode_q)
                MODE_IDLE: begin
                    if (en) begin
                        if (div == '0) begin
                            mode_q <= MODE_PASS;
                        end else begin
                            mode_q    <= MODE_DIV;
                            cur_n_q   <= div;
                            cur_sym_q <= sym;
                            cnt_q     <= '0;
                            out_q     <= 1'b1;
                        end
                    end
                end
                MODE_DIV: begin
                    if (at_end) begin
                        cnt_q <= '0;
                        if (!en) begin
                            mode_q <= MODE_IDLE;
                            out_q  <= 1'b0;
                        end else if (div == '0) begin
                            mode_q <= MODE_PASS;
                            out_q  <= 1'b0;
                        end else begin
                            cur_n_q   <= div;
                            cur_sym_q <= sym;
                            out_q     <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_inc;
                        out_q <= phase_high(cnt_inc, cur_n_q, cur_sym_q);
                    end
                end
                MODE_PASS: begin
                    if (!en || div != '0)
                        mode_q <= MODE_IDLE;
                end
                default: mode_q <= MODE_IDLE;
            endcase
        end
    end

    assign pulse    = out_q;
    assign pass_req = (mode_q == MODE_PASS);
    assign busy     = (mode_q == MODE_DIV);

    // clear stops everything on the next cycle
    assert_clear_stops_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mode_q == MODE_IDLE && !out_q));

    // active factor and shape only change at a period boundary
    assert_switch_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DIV && !at_end && !clr) |=> ($stable(cur_n_q) && $stable(cur_sym_q)));

    // count never runs past the end of the period
    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DIV) |-> (cnt_q <= last));

    // no divided pulse unless counting
    assert_quiet_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_DIV) |-> !out_q);

    // enable drop at period end goes idle
    assert_stop_after_period_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DIV && at_end && !en && !clr) |=> (mode_q == MODE_IDLE));

endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    input  logic pass_req,
    input  logic inv,
    output logic clk_out
);

    logic gate_q;

    // gate updated while clk is low so pass-through never clips a phase
    always_ff @(negedge clk) begin
        if (rst)
            gate_q <= 1'b0;
        else
            gate_q <= pass_req;
    end

    // inverter is the very last element
    assign clk_out = (pulse | (clk & gate_q)) ^ inv;

    assert_rest_level_R9: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !gate_q) |-> (clk_out == inv));

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       port_clk_en,
    output logic       clk_out
);

    ctrl_t ctrl;
    logic  clr_pulse;
    logic  busy;
    logic  pulse;
    logic  pass_req;

    clkdiv_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .busy      (busy),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse),
        .rd_data   (rd_data)
    );

    clkdiv_core u_core (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_pulse),
        .en       (port_clk_en),
        .div      (ctrl.div),
        .sym      (ctrl.sym),
        .pulse    (pulse),
        .pass_req (pass_req),
        .busy     (busy)
    );

    clkdiv_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .pulse    (pulse),
        .pass_req (pass_req),
        .inv      (ctrl.inv),
        .clk_out  (clk_out)
    );

endmodule

// File: tb/tb_clkout_divider.sv
module tb_clkout_divider;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {div[4:0], sym, inv, high[6:0], low[6:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {5'd1,  1'b1, 1'b0, 7'd1,  7'd1},
        {5'd1,  1'b0, 1'b0, 7'd1,  7'd1},
        {5'd2,  1'b1, 1'b0, 7'd2,  7'd2},
        {5'd3,  1'b0, 1'b0, 7'd1,  7'd5},
        {5'd5,  1'b1, 1'b1, 7'd5,  7'd5},
        {5'd7,  1'b0, 1'b1, 7'd1,  7'd13},
        {5'd31, 1'b1, 1'b0, 7'd31, 7'd31},
        {5'd31, 1'b0, 1'b0, 7'd1,  7'd61}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       port_clk_en = 1'b0;
    logic       clk_out;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    clkout_divider dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .port_clk_en (port_clk_en),
        .clk_out     (clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance to just after the next falling edge
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic run_len(input logic pol, input logic lvl, output int n);
        n = 0;
        while (((clk_out ^ pol) == lvl) && n < 200) begin
            n++;
            step();
        end
    endtask

    // ends on the first high sample of a fresh period
    task automatic measure(input logic pol, output int hi, output int lo);
        int dummy;
        run_len(pol, 1'b1, dummy);
        run_len(pol, 1'b0, dummy);
        run_len(pol, 1'b1, hi);
        run_len(pol, 1'b0, lo);
    endtask

    initial begin
        int hi, lo, hi2, lo2;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 rd_data", rd_data, 8'h80);
        check("R1 clk_out", clk_out, 0);

        // R4 pass-through with divide field 0
        port_clk_en = 1'b1;
        write(8'h00);
        repeat (4) step();
        @(posedge clk); #(CLK_PERIOD/4);
        check("R4 high phase", clk_out, 1);
        @(negedge clk); #(CLK_PERIOD/4);
        check("R4 low phase", clk_out, 0);
        check("R4 idle flag", rd_data[7], 1);
        step();

        // R2/R3/R9 vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [4:0] vd;
            logic vs, vi;
            vd = VEC[i][20:16];
            vs = VEC[i][15];
            vi = VEC[i][14];
            write({1'b1, vi, vs, vd});
            measure(vi, hi, lo);
            check(vs ? "R2 high run" : "R3 high run", hi, int'(VEC[i][13:7]));
            check(vs ? "R2 low run" : "R3 low run", lo, int'(VEC[i][6:0]));
        end

        // R2 every divide value
        for (int n = 1; n < 32; n++) begin
            write({3'b101, 5'(n)});
            measure(1'b0, hi, lo);
            check("R2 period", hi + lo, 2 * n);
        end

        // R5 change lands at boundary
        write(8'hA4);
        measure(1'b0, hi, lo);
        wr_en = 1'b1; wr_data = 8'h22;
        step();
        wr_en = 1'b0;
        run_len(1'b0, 1'b1, hi);
        run_len(1'b0, 1'b0, lo);
        check("R5 old high rest", hi, 3);
        check("R5 old low", lo, 4);
        run_len(1'b0, 1'b1, hi2);
        run_len(1'b0, 1'b0, lo2);
        check("R5 new high", hi2, 2);
        check("R5 new low", lo2, 2);
        check("R10 readback div", rd_data[6:0], 7'h22);

        // R6 clear mid-period with new factor
        measure(1'b0, hi, lo);
        wr_en = 1'b1; wr_data = 8'hA3;
        step();
        wr_en = 1'b0;
        check("R6 forced low", clk_out, 0);
        check("R7 idle after clear", rd_data[7], 1);
        step();
        check("R6 restart high", clk_out, 1);
        check("R10 flag live after clear", rd_data[7], 0);
        run_len(1'b0, 1'b1, hi);
        run_len(1'b0, 1'b0, lo);
        check("R6 new high", hi, 3);
        check("R6 new low", lo, 3);

        // R8 enable drop finishes the period
        port_clk_en = 1'b0;
        step();
        run_len(1'b0, 1'b1, hi);
        check("R8 high completes", hi, 2);
        check("R7 busy in low", rd_data[7], 0);
        step(); step();
        check("R7 busy last cycle", rd_data[7], 0);
        check("R8 last cycle low", clk_out, 0);
        step();
        check("R7 idle after stop", rd_data[7], 1);
        check("R8 rest low", clk_out, 0);

        // R9 invert while stopped and immediate effect
        write(8'h43);
        check("R9 rest inverted", clk_out, 1);
        check("R10 readback inv", rd_data[6:0], 7'h43);
        repeat (10) step();
        check("R9 stays at rest", clk_out, 1);
        write(8'h03);
        check("R9 back to zero", clk_out, 0);

        // R8/R9 disable with invert set
        write(8'h63);
        port_clk_en = 1'b1;
        measure(1'b1, hi, lo);
        check("R9 inverted high run", hi, 3);
        port_clk_en = 1'b0;
        repeat (20) step();
        check("R8 rest at inv level", clk_out, 1);
        check("R7 idle with inv", rd_data[7], 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule